// File: doc/BRIEF.md
# External DMA Request Logger

This block sits between a companion chip and a DMA channel engine. The companion chip signals a transfer request by raising one of three request pins. These pins are not synchronous to the local clock. Each pin goes through a two-flop synchronizer and then a width qualifier. A rising edge is accepted only if the low phase before it lasted at least four clock cycles and the high phase after it also lasts four cycles. Each accepted edge adds one to a pending count for that pin. A pin can hold up to 31 pending requests.

The channel engine starts one memory bus cycle for each pending request. It tells the block by pulsing a consume strobe together with the index of the pin it serves. The block then takes one request off that pin's count. One cycle later it reports the served pin to the companion chip on a two-bit valid code. Pins 0 and 1 may be served by either transfer mode. Pin 2 is limited to flow-through transfers. If pin 2 is configured for fly-by, its pending indication is masked and a sticky mode-error flag is raised.

Top module: `dreq_logger`

## Requirements
- R1: A rising edge on a request pin is counted exactly once, and only after the pin has been high for 4 synchronized cycles following a low phase of at least 4 cycles. Holding the pin high adds nothing further. Pin k's count appears on `pend_cnt_o[5k+4:5k]`.
- R2: A high phase shorter than 4 synchronized cycles adds nothing to the count and sets the sticky bit `width_err_o[k]` for that pin.
- R3: A low phase shorter than 4 cycles between two high phases sets `width_err_o[k]`, and the rising edge that ends it is not counted.
- R4: Each pin's count tracks accepted edges minus served requests, up to 31, with no interaction between pins.
- R5: An accepted edge that arrives when the count is already 31 leaves the count at 31 and sets the sticky bit `ovf_o[k]`.
- R6: A consume strobe (`consume_vld_i`=1, `consume_pin_i`=k, k in 0..2) lowers pin k's count by one at the next clock edge. A strobe aimed at a pin whose count is 0 changes nothing.
- R7: If an accepted edge and a consume for the same pin fall in the same cycle, that pin's count stays unchanged.
- R8: One cycle after a consume that is accepted, `valid_o` carries the code k+1 for served pin k (01, 10, 11). In every other cycle it is 00.
- R9: `pend_o[k]` is high exactly when pin k's count is nonzero. The one exception: while `hi_pin_flyby_i`=1, `pend_o[2]` is held low and `mode_err_o` is set at the next edge. `mode_err_o` then stays set until reset.
- R10: While `rst_ni` is low and after reset, every count, flag, pending bit and valid code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_pin_i | input | 3 | Asynchronous request pins from the companion chip |
| consume_vld_i | input | 1 | Channel engine starts a bus cycle for one request |
| consume_pin_i | input | 2 | Index of the pin being served |
| hi_pin_flyby_i | input | 1 | Pin 2 transfer mode: 1 = fly-by (not allowed), 0 = flow-through |
| pend_cnt_o | output | 15 | Pending counts, 5 bits per pin, pin 0 in the low bits |
| pend_o | output | 3 | Per-pin request pending |
| width_err_o | output | 3 | Sticky per-pin width violation |
| ovf_o | output | 3 | Sticky per-pin overflow |
| mode_err_o | output | 1 | Sticky fly-by-on-pin-2 error |
| valid_o | output | 2 | Served-pin code to the companion chip |

## Verification
Two functions can land on one pin in the same cycle: accepting a new edge and consuming a pending request. The bench provokes this on purpose. It raises pin 1 while that pin already holds a count of two, then counts clock edges through the synchronizer and the qualifier so that the consume strobe arrives in exactly the cycle the edge is accepted. The check passes if the count stays at two while the valid code still reports pin 1 on the following cycle. The bench also saturates a counter and drains it to show that counting and consuming stay correct at both ends of the range.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;

    // Transfer style selected for a request pin
    typedef enum logic {
        XFER_FLOWTHRU = 1'b0,
        XFER_FLYBY    = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/dreq_sync.sv
`timescale 1ns/1ps
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dreq_qualifier.sv
`timescale 1ns/1ps
module dreq_qualifier #(
    parameter int MINW = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic qual_o,
    output logic viol_o
);
    localparam int RW = $clog2(MINW + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(MINW);
    localparam logic [RW-1:0] RUN_LAST = RW'(MINW - 1);

    typedef struct packed {
        logic          lvl;
        logic [RW-1:0] run;
        logic          low_ok;
        logic          viol;
    } qst_t;

    qst_t st_d, st_q;

    // Accept on the MINW-th high sample if the preceding low was long enough
    assign qual_o = st_q.lvl && lvl_i && (st_q.run == RUN_LAST) && st_q.low_ok;

    always_comb begin
        st_d = st_q;
        if (lvl_i != st_q.lvl) begin
            st_d.lvl = lvl_i;
            st_d.run = RW'(1);
            if (st_q.run < RUN_FULL) st_d.viol = 1'b1;
            if (lvl_i) st_d.low_ok = (st_q.run == RUN_FULL);
        end else if (st_q.run != RUN_FULL) begin
            st_d.run = st_q.run + RW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lvl    <= 1'b0;
            st_q.run    <= RUN_FULL;
            st_q.low_ok <= 1'b1;
            st_q.viol   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_o = st_q.viol;

    // R1
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qual_o |=> !qual_o);

    // R2
    short_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(viol_o) |-> ($past(lvl_i) != $past(st_q.lvl)));
endmodule

// File: rtl/dreq_counter.sv
`timescale 1ns/1ps
module dreq_counter #(
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          take_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } cst_t;

    cst_t st_d, st_q;

    assign take_o = dec_i && (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (inc_i && take_o) begin
            st_d.cnt = st_q.cnt;
        end else if (inc_i) begin
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
            else                     st_d.cnt = st_q.cnt + CW'(1);
        end else if (take_o) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    // R5
    ovf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> ($past(cnt_o) == CNT_MAX && cnt_o == CNT_MAX));

    // R6
    zero_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !inc_i && cnt_o == '0) |=> (cnt_o == '0));

    // R7
    net_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && dec_i && cnt_o != '0) |=> $stable(cnt_o));
endmodule

// File: rtl/dreq_logger.sv
`timescale 1ns/1ps
module dreq_logger
    import dreq_pkg::*;
#(
    parameter int NPINS  = 3,
    parameter int CW     = 5,
    parameter int MINW   = 4,
    parameter int SYNC   = 2,
    parameter int FO_PIN = 2,
    localparam int PW    = $clog2(NPINS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NPINS-1:0]    req_pin_i,
    input  logic                consume_vld_i,
    input  logic [PW-1:0]       consume_pin_i,
    input  logic                hi_pin_flyby_i,
    output logic [NPINS*CW-1:0] pend_cnt_o,
    output logic [NPINS-1:0]    pend_o,
    output logic [NPINS-1:0]    width_err_o,
    output logic [NPINS-1:0]    ovf_o,
    output logic                mode_err_o,
    output logic [PW-1:0]       valid_o
);
    typedef struct packed {
        logic [PW-1:0] valid;
        logic          mode_err;
    } tst_t;

    tst_t             st_d, st_q;
    xfer_mode_e       hi_mode;
    logic [NPINS-1:0] lvl_w, qual_w, dec_w, take_w;

    assign hi_mode = xfer_mode_e'(hi_pin_flyby_i);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign dec_w[i] = consume_vld_i && (consume_pin_i == PW'(i));

        dreq_sync #(.STAGES(SYNC)) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .d_i   (req_pin_i[i]),
            .q_o   (lvl_w[i])
        );

        dreq_qualifier #(.MINW(MINW)) u_qual (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .lvl_i (lvl_w[i]),
            .qual_o(qual_w[i]),
            .viol_o(width_err_o[i])
        );

        dreq_counter #(.CW(CW)) u_cnt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .inc_i (qual_w[i]),
            .dec_i (dec_w[i]),
            .cnt_o (pend_cnt_o[i*CW +: CW]),
            .ovf_o (ovf_o[i]),
            .take_o(take_w[i])
        );

        if (i == FO_PIN) begin : g_fo
            assign pend_o[i] = (|pend_cnt_o[i*CW +: CW]) && (hi_mode != XFER_FLYBY);
        end else begin : g_any
            assign pend_o[i] = |pend_cnt_o[i*CW +: CW];
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.valid    = '0;
        st_d.mode_err = st_q.mode_err || (hi_mode == XFER_FLYBY);
        for (int i = 0; i < NPINS; i++) begin
            if (take_w[i]) st_d.valid = PW'(i + 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o    = st_q.valid;
    assign mode_err_o = st_q.mode_err;

    // R8
    valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o != '0) |-> ($past(consume_vld_i) && ($past(consume_pin_i) + PW'(1) == valid_o)));

    // R9
    flyby_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_mode == XFER_FLYBY) |-> !pend_o[FO_PIN]);

    // R9
    mode_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_mode == XFER_FLYBY) |=> mode_err_o);
endmodule

// File: tb/test_dreq_logger.sv
`timescale 1ns/1ps
module test_dreq_logger;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  req_pin;
    logic        cvld;
    logic [1:0]  cpin;
    logic        flyby;
    logic [14:0] pcnt;
    logic [2:0]  pend, werr, ovf;
    logic        merr;
    logic [1:0]  valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dreq_logger i_dreq_logger (
        .clk_i(clk), .rst_ni(rst_n), .req_pin_i(req_pin),
        .consume_vld_i(cvld), .consume_pin_i(cpin), .hi_pin_flyby_i(flyby),
        .pend_cnt_o(pcnt), .pend_o(pend), .width_err_o(werr), .ovf_o(ovf),
        .mode_err_o(merr), .valid_o(valid)
    );

    // fields: pin[23:22] h1[21:16] gap[15:10] h2[9:4] exp_cnt[3:1] exp_err[0]
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 6'd4,  6'd0, 6'd0, 3'd1, 1'b0},   // R1 minimum clean pulse
        {2'd1, 6'd10, 6'd0, 6'd0, 3'd1, 1'b0},   // R1 long level counts once
        {2'd2, 6'd3,  6'd0, 6'd0, 3'd0, 1'b1},   // R2 high too short
        {2'd0, 6'd4,  6'd4, 6'd5, 3'd2, 1'b0},   // R4 two clean edges
        {2'd1, 6'd5,  6'd2, 6'd6, 3'd1, 1'b1},   // R3 low too short
        {2'd2, 6'd1,  6'd0, 6'd0, 3'd0, 1'b1},   // R2 single-cycle glitch
        {2'd0, 6'd6,  6'd3, 6'd6, 3'd1, 1'b1}    // R3 low one cycle short
    };

    function automatic int cnt_of(int p);
        return int'(pcnt[p*5 +: 5]);
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_pin = '0; cvld = 1'b0; cpin = '0; flyby = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(int p, int h, int lo);
        req_pin[p] = 1'b1;
        repeat (h) @(negedge clk);
        req_pin[p] = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic consume(int p);
        cvld = 1'b1; cpin = 2'(p);
        @(negedge clk);
        cvld = 1'b0;
    endtask

    initial begin
        do_reset();
        // R10 reset state
        check("R10 counts", int'(pcnt), 0);
        check("R10 flags", int'({pend, werr, ovf, merr, valid}), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int p, h1, gap, h2;
            p = int'(VEC[v][23:22]); h1 = int'(VEC[v][21:16]);
            gap = int'(VEC[v][15:10]); h2 = int'(VEC[v][9:4]);
            do_reset();
            if (h2 == 0) pulse(p, h1, 12);
            else begin
                pulse(p, h1, gap);
                pulse(p, h2, 12);
            end
            check($sformatf("R1/R2/R3/R4 vec%0d count", v), cnt_of(p), int'(VEC[v][3:1]));
            check($sformatf("R2/R3 vec%0d width_err", v), int'(werr[p]), int'(VEC[v][0]));
            check($sformatf("R4 vec%0d other pins", v), int'(pcnt) - (cnt_of(p) << (5*p)), 0);
        end

        // R5 saturation and overflow
        do_reset();
        for (int k = 0; k < 32; k++) pulse(0, 5, 5);
        repeat (6) @(negedge clk);
        check("R5 saturated count", cnt_of(0), 31);
        check("R5 overflow flag", int'(ovf), 1);
        check("R9 pend follows count", int'(pend), 1);

        // R6 drain plus R8 valid code
        consume(0);
        check("R8 valid code pin0", int'(valid), 1);
        @(negedge clk);
        check("R8 valid returns to zero", int'(valid), 0);
        for (int k = 0; k < 30; k++) consume(0);
        check("R6 drained", cnt_of(0), 0);
        consume(0);
        check("R6 consume at zero", cnt_of(0), 0);
        check("R8 no valid at zero", int'(valid), 0);
        check("R9 pend clears", int'(pend), 0);

        // R7 edge and consume in the same cycle on pin 1
        do_reset();
        pulse(1, 5, 6);
        pulse(1, 5, 6);
        check("R7 setup count", cnt_of(1), 2);
        req_pin[1] = 1'b1;
        repeat (5) @(negedge clk);
        cvld = 1'b1; cpin = 2'd1;
        @(negedge clk);
        cvld = 1'b0;
        check("R8 valid code pin1", int'(valid), 2);
        repeat (2) @(negedge clk);
        req_pin[1] = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 net unchanged", cnt_of(1), 2);

        // R9 fly-by on pin 2
        do_reset();
        pulse(2, 5, 10);
        check("R9 pin2 pend", int'(pend[2]), 1);
        consume(2);
        check("R8 valid code pin2", int'(valid), 3);
        pulse(2, 5, 10);
        flyby = 1'b1;
        #1;
        check("R9 pin2 masked", int'(pend[2]), 0);
        @(negedge clk);
        check("R9 mode error set", int'(merr), 1);
        flyby = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 mode error sticky", int'(merr), 1);
        check("R9 pin2 unmasked", int'(pend[2]), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule